// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a key matrix whose active size is chosen at run time, from 3x3 up to the synthesized maximum of 8x8. It pulls one scan row low at a time and reads the column lines. The columns are pulled up, so a closed switch reads low. The samples of one pass are assembled into a full matrix image. That image becomes the reported key map only after it has repeated for a programmable number of consecutive passes. Each accepted change sets a sticky press flag or a sticky release flag, or both. Each flag stays set until a clear pulse is applied.

In low-power mode the clocked scan stops and every configured row is pulled low at once. Any pressed key inside the configured area then raises the wake output through a purely combinational path, so the wake works even when the clock is gated. Three key positions, each given as a row/column index, form a reset chord. When all three stay pressed in the debounced map for a programmable number of clocks, a reset request is raised.

Top module: `kpd_matrix_scan`

## Requirements
- R1: After a synchronous reset, key_map is zero, both flags and reset_req are low, and scan_out is 8'hFE: only row 0 is driven low, and 1 means the row is released.
- R2: Outside low-power mode, exactly one row is driven low at a time. Each row is held for STEP_CYC (2) clocks, and the rows step from 0 to the configured count minus one, then wrap. A configured size below 3 is treated as 3 and one above 8 as 8, for rows and columns alike.
- R3: key_map takes a new matrix image only after that same image has been seen in cfg_dbnc consecutive full scans. A cfg_dbnc of 0 acts as 1. A shorter glitch never reaches key_map.
- R4: key_map bit row*8+col is 1 when that key is pressed. Keys in rows or columns outside the configured size always read 0.
- R5: press_flag is set when an accepted image adds a pressed key. It holds until a clr_press pulse clears it. A set in the same cycle as a clear wins.
- R6: release_flag behaves the same way for an accepted image that removes a pressed key, and is cleared by clr_release.
- R7: While lp_mode is high, every configured row is driven low, scanning and key_map are frozen, and wake follows combinationally whether any configured column reads low. With lp_mode low, wake is 0.
- R8: reset_req rises on the (combo_hold+1)-th consecutive clock at which the three keys combo_key0, combo_key1 and combo_key2 are all set in key_map. It drops one clock after any of them clears. Each index is {row[5:3], col[2:0]}, and a key outside the configured size never counts as pressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rows | input | 4 | Configured row count (clamped to 3..8) |
| cfg_cols | input | 4 | Configured column count (clamped to 3..8) |
| cfg_dbnc | input | 4 | Matching full scans needed to accept an image (0 acts as 1) |
| lp_mode | input | 1 | Low-power mode: all rows low, no scanning |
| scan_in | input | 8 | Column inputs, pulled up, low = key closed on driven row |
| clr_press | input | 1 | Clear pulse for press_flag |
| clr_release | input | 1 | Clear pulse for release_flag |
| combo_key0 | input | 6 | First reset-chord key index {row,col} |
| combo_key1 | input | 6 | Second reset-chord key index {row,col} |
| combo_key2 | input | 6 | Third reset-chord key index {row,col} |
| combo_hold | input | 8 | Clocks the chord must persist before reset_req |
| scan_out | output | 8 | Row drive, 0 = pulled low, 1 = released |
| key_map | output | 64 | Debounced pressed-key bitmap, bit row*8+col |
| press_flag | output | 1 | Sticky press event flag |
| release_flag | output | 1 | Sticky release event flag |
| wake | output | 1 | Wake request in low-power mode |
| reset_req | output | 1 | Three-key chord reset request |

## Verification
Faults in the row or step counters show on scan_out in the very next clock. Because they also corrupt the sampled image, key_map goes wrong within one full scan. A faulty debounce count or a faulty image register shows as key_map updating one scan early or late, or as a glitch key getting through. The reference model catches this at the frame boundary where the update happens. Errors in the flags or in the chord hold counter appear on press_flag, release_flag or reset_req within a cycle of the event, because the bench compares every output on every clock.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int DIM_MIN = 3;

  // Clamp a requested matrix dimension into the supported range.
  function automatic int fit_dim(input int req, input int top);
    int v;
    v = req;
    if (v < DIM_MIN) v = DIM_MIN;
    if (v > top) v = top;
    return v;
  endfunction
endpackage

// File: rtl/kpd_row_seq.sv
module kpd_row_seq #(
  parameter int ROWS     = 8,
  parameter int STEP_CYC = 2,
  parameter int CFG_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lp_mode,
  input  logic [CFG_W-1:0] rows_eff,
  output logic [CFG_W-1:0] row_idx,
  output logic             sample,
  output logic             frame_end,
  output logic [ROWS-1:0]  scan_out
);
  localparam int SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYC - 1);

  logic [SW-1:0]    step_q;
  logic [CFG_W-1:0] row_q;

  assign sample    = !lp_mode && (step_q == STEP_LAST);
  assign frame_end = sample && (row_q >= rows_eff - CFG_W'(1));
  assign row_idx   = row_q;

  always_ff @(posedge clk) begin
    if (rst || lp_mode) begin
      step_q <= '0;
      row_q  <= '0;
    end else if (sample) begin
      step_q <= '0;
      row_q  <= frame_end ? '0 : row_q + CFG_W'(1);
    end else begin
      step_q <= step_q + SW'(1);
    end
  end

  // Row drive: one row low while scanning, every configured row low in low power.
  for (genvar i = 0; i < ROWS; i++) begin : g_drive
    assign scan_out[i] = lp_mode ? !(CFG_W'(i) < rows_eff) : (row_q != CFG_W'(i));
  end
endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int CFG_W = 4,
  parameter int DB_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample,
  input  logic                 frame_end,
  input  logic [CFG_W-1:0]     row_idx,
  input  logic [COLS-1:0]      col_hits,
  input  logic [ROWS-1:0]      row_en,
  input  logic [DB_W-1:0]      need,
  input  logic                 clr_press,
  input  logic                 clr_release,
  output logic [ROWS*COLS-1:0] key_q,
  output logic                 press_q,
  output logic                 release_q
);
  localparam int NK = ROWS * COLS;

  logic [NK-1:0]   frame_q, prev_q, img, full, row_bits;
  logic [DB_W-1:0] cnt_q, cnt_nx;
  logic            accept, rise, fall;

  for (genvar r = 0; r < ROWS; r++) begin : g_rowmask
    assign row_bits[r*COLS +: COLS] = {COLS{row_en[r]}};
  end

  always_comb begin
    img = frame_q;
    for (int r = 0; r < ROWS; r++)
      if (row_idx == CFG_W'(r)) img[r*COLS +: COLS] = col_hits;
  end

  assign full   = img & row_bits;
  assign cnt_nx = (full == prev_q) ? ((&cnt_q) ? cnt_q : cnt_q + DB_W'(1)) : DB_W'(1);
  assign accept = sample && frame_end && (cnt_nx >= need);
  assign rise   = accept && |(full & ~key_q);
  assign fall   = accept && |(key_q & ~full);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q   <= '0;
      prev_q    <= '0;
      cnt_q     <= '0;
      key_q     <= '0;
      press_q   <= 1'b0;
      release_q <= 1'b0;
    end else begin
      if (sample) begin
        if (frame_end) begin
          prev_q  <= full;
          frame_q <= '0;
          cnt_q   <= cnt_nx;
          if (accept) key_q <= full;
        end else begin
          frame_q <= img;
        end
      end
      press_q   <= rise | (press_q & ~clr_press);
      release_q <= fall | (release_q & ~clr_release);
    end
  end
endmodule

// File: rtl/kpd_combo_rst.sv
module kpd_combo_rst #(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int IDX_W  = 6,
  parameter int HOLD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROWS*COLS-1:0] keys,
  input  logic [IDX_W-1:0]     k0,
  input  logic [IDX_W-1:0]     k1,
  input  logic [IDX_W-1:0]     k2,
  input  logic [HOLD_W-1:0]    hold,
  output logic                 req_q
);
  localparam int CB = $clog2(COLS);

  function automatic logic key_at(input logic [ROWS*COLS-1:0] km, input logic [IDX_W-1:0] ix);
    int r, c;
    logic v;
    r = int'(ix[IDX_W-1:CB]);
    c = int'(ix[CB-1:0]);
    v = 1'b0;
    for (int i = 0; i < ROWS*COLS; i++)
      if (r < ROWS && c < COLS && i == r*COLS + c) v = km[i];
    return v;
  endfunction

  logic              combo;
  logic [HOLD_W-1:0] cnt_q;

  assign combo = key_at(keys, k0) & key_at(keys, k1) & key_at(keys, k2);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= combo ? ((&cnt_q) ? cnt_q : cnt_q + HOLD_W'(1)) : '0;
      req_q <= combo && (cnt_q >= hold);
    end
  end
endmodule

// File: rtl/kpd_matrix_scan.sv
module kpd_matrix_scan #(
  parameter int MAX_ROWS = 8,
  parameter int MAX_COLS = 8,
  parameter int STEP_CYC = 2,
  parameter int DB_W     = 4,
  parameter int HOLD_W   = 8,
  parameter int IDX_W    = $clog2(MAX_ROWS) + $clog2(MAX_COLS),
  parameter int CFG_W    = $clog2(((MAX_ROWS > MAX_COLS) ? MAX_ROWS : MAX_COLS) + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CFG_W-1:0]             cfg_rows,
  input  logic [CFG_W-1:0]             cfg_cols,
  input  logic [DB_W-1:0]              cfg_dbnc,
  input  logic                         lp_mode,
  input  logic [MAX_COLS-1:0]          scan_in,
  input  logic                         clr_press,
  input  logic                         clr_release,
  input  logic [IDX_W-1:0]             combo_key0,
  input  logic [IDX_W-1:0]             combo_key1,
  input  logic [IDX_W-1:0]             combo_key2,
  input  logic [HOLD_W-1:0]            combo_hold,
  output logic [MAX_ROWS-1:0]          scan_out,
  output logic [MAX_ROWS*MAX_COLS-1:0] key_map,
  output logic                         press_flag,
  output logic                         release_flag,
  output logic                         wake,
  output logic                         reset_req
);
  import kpd_pkg::*;

  localparam int NK = MAX_ROWS * MAX_COLS;

  logic [CFG_W-1:0]    rows_eff, cols_eff, row_idx;
  logic [MAX_ROWS-1:0] row_en;
  logic [MAX_COLS-1:0] col_en, col_hits;
  logic [DB_W-1:0]     need;
  logic [NK-1:0]       key_raw, key_mask;
  logic                sample, frame_end;

  assign rows_eff = CFG_W'(fit_dim(int'(cfg_rows), MAX_ROWS));
  assign cols_eff = CFG_W'(fit_dim(int'(cfg_cols), MAX_COLS));
  assign need     = (cfg_dbnc == '0) ? DB_W'(1) : cfg_dbnc;

  for (genvar r = 0; r < MAX_ROWS; r++) begin : g_ren
    assign row_en[r] = CFG_W'(r) < rows_eff;
  end
  for (genvar c = 0; c < MAX_COLS; c++) begin : g_cen
    assign col_en[c] = CFG_W'(c) < cols_eff;
  end
  for (genvar r = 0; r < MAX_ROWS; r++) begin : g_kmask
    assign key_mask[r*MAX_COLS +: MAX_COLS] = col_en & {MAX_COLS{row_en[r]}};
  end

  assign col_hits = ~scan_in & col_en;
  assign wake     = lp_mode && |col_hits;
  assign key_map  = key_raw & key_mask;

  kpd_row_seq #(.ROWS(MAX_ROWS), .STEP_CYC(STEP_CYC), .CFG_W(CFG_W)) i_seq (
    .clk(clk), .rst(rst), .lp_mode(lp_mode), .rows_eff(rows_eff),
    .row_idx(row_idx), .sample(sample), .frame_end(frame_end), .scan_out(scan_out)
  );

  kpd_debounce #(.ROWS(MAX_ROWS), .COLS(MAX_COLS), .CFG_W(CFG_W), .DB_W(DB_W)) i_deb (
    .clk(clk), .rst(rst), .sample(sample), .frame_end(frame_end), .row_idx(row_idx),
    .col_hits(col_hits), .row_en(row_en), .need(need),
    .clr_press(clr_press), .clr_release(clr_release),
    .key_q(key_raw), .press_q(press_flag), .release_q(release_flag)
  );

  kpd_combo_rst #(.ROWS(MAX_ROWS), .COLS(MAX_COLS), .IDX_W(IDX_W), .HOLD_W(HOLD_W)) i_combo (
    .clk(clk), .rst(rst), .keys(key_map),
    .k0(combo_key0), .k1(combo_key1), .k2(combo_key2), .hold(combo_hold),
    .req_q(reset_req)
  );
endmodule

// File: rtl/kpd_matrix_scan_chk.sv
module kpd_matrix_scan_chk #(
  parameter int MAX_ROWS = 8,
  parameter int MAX_COLS = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         lp_mode,
  input logic                         clr_press,
  input logic                         clr_release,
  input logic [MAX_ROWS-1:0]          scan_out,
  input logic [MAX_ROWS*MAX_COLS-1:0] key_map,
  input logic                         press_flag,
  input logic                         release_flag,
  input logic                         wake,
  input logic                         reset_req
);
  // R2
  one_row_low_chk: assert property (@(posedge clk) disable iff (rst)
    !lp_mode |-> $countones(~scan_out) == 1);

  // R7
  lp_rows_low_chk: assert property (@(posedge clk) disable iff (rst)
    lp_mode |-> $countones(~scan_out) >= 3);

  // R7
  wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !lp_mode |-> !wake);

  // R7
  lp_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    lp_mode |=> (!lp_mode || $stable(key_map)));

  // R5
  press_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    press_flag && !clr_press |=> press_flag);

  // R6
  release_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    release_flag && !clr_release |=> release_flag);

  // R5
  press_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(press_flag) |-> (key_map & ~$past(key_map)) != '0);

  // R8
  chord_cause_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $countones($past(key_map)) >= 3);
endmodule

bind kpd_matrix_scan kpd_matrix_scan_chk #(.MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS)) i_chk (
  .clk(clk), .rst(rst), .lp_mode(lp_mode), .clr_press(clr_press), .clr_release(clr_release),
  .scan_out(scan_out), .key_map(key_map), .press_flag(press_flag),
  .release_flag(release_flag), .wake(wake), .reset_req(reset_req)
);

// File: tb/test_kpd_matrix_scan.sv
module test_kpd_matrix_scan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_rows = 4'd8, cfg_cols = 4'd8, cfg_dbnc = 4'd2;
  logic        lp_mode = 1'b0, clr_press = 1'b0, clr_release = 1'b0;
  logic [7:0]  scan_in;
  logic [5:0]  combo_key0 = 6'd0, combo_key1 = 6'd10, combo_key2 = 6'd63;
  logic [7:0]  combo_hold = 8'd5;
  logic [7:0]  scan_out;
  logic [63:0] key_map;
  logic        press_flag, release_flag, wake, reset_req;

  bit [7:0] keys [8];
  int  n_chk = 0, n_fail = 0;
  bit  chk_on = 0, done = 0;

  always #10 clk = ~clk;

  kpd_matrix_scan i_kpd_matrix_scan (
    .clk(clk), .rst(rst), .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_dbnc(cfg_dbnc),
    .lp_mode(lp_mode), .scan_in(scan_in), .clr_press(clr_press), .clr_release(clr_release),
    .combo_key0(combo_key0), .combo_key1(combo_key1), .combo_key2(combo_key2),
    .combo_hold(combo_hold), .scan_out(scan_out), .key_map(key_map),
    .press_flag(press_flag), .release_flag(release_flag), .wake(wake), .reset_req(reset_req)
  );

  // Physical matrix: a column reads low if a driven-low row has that key closed.
  always_comb begin
    for (int c = 0; c < 8; c++) begin
      scan_in[c] = 1'b1;
      for (int r = 0; r < 8; r++)
        if (!scan_out[r] && keys[r][c]) scan_in[c] = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic int fit(input int v);
    if (v < 3) return 3;
    if (v > 8) return 8;
    return v;
  endfunction

  function automatic bit [63:0] kmask(input int re, input int ce);
    bit [63:0] m = '0;
    for (int r = 0; r < re; r++)
      for (int c = 0; c < ce; c++) m[r*8+c] = 1'b1;
    return m;
  endfunction

  // Behavioural reference model
  int m_row = 0, m_step = 0, m_cnt = 0, m_hcnt = 0;
  bit [63:0] m_frame = '0, m_prev = '0, m_key = '0;
  bit m_pf = 0, m_rf = 0, m_rreq = 0;

  always @(posedge clk) begin
    int re, ce, need;
    bit [63:0] full, mk;
    bit combo, ps, rs;
    re = fit(int'(cfg_rows));
    ce = fit(int'(cfg_cols));
    need = (cfg_dbnc == 0) ? 1 : int'(cfg_dbnc);
    if (rst) begin
      m_row = 0; m_step = 0; m_cnt = 0; m_hcnt = 0;
      m_frame = '0; m_prev = '0; m_key = '0;
      m_pf = 0; m_rf = 0; m_rreq = 0;
    end else begin
      mk = m_key & kmask(re, ce);
      combo = mk[combo_key0] & mk[combo_key1] & mk[combo_key2];
      m_rreq = combo && (m_hcnt >= int'(combo_hold));
      m_hcnt = combo ? ((m_hcnt < 255) ? m_hcnt + 1 : 255) : 0;
      ps = 0; rs = 0;
      if (lp_mode) begin
        m_row = 0; m_step = 0;
      end else if (m_step == 1) begin
        m_step = 0;
        for (int c = 0; c < 8; c++) m_frame[m_row*8+c] = (c < ce) && keys[m_row][c];
        if (m_row >= re - 1) begin
          full = m_frame & kmask(re, 8);
          m_cnt = (full == m_prev) ? ((m_cnt < 15) ? m_cnt + 1 : 15) : 1;
          m_prev = full;
          m_frame = '0;
          if (m_cnt >= need) begin
            ps = |(full & ~m_key);
            rs = |(m_key & ~full);
            m_key = full;
          end
          m_row = 0;
        end else begin
          m_row = m_row + 1;
        end
      end else begin
        m_step = m_step + 1;
      end
      m_pf = ps | (m_pf & !clr_press);
      m_rf = rs | (m_rf & !clr_release);
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    int re, ce;
    bit [7:0] es;
    bit ew;
    if (chk_on) begin
      re = fit(int'(cfg_rows));
      ce = fit(int'(cfg_cols));
      ew = 0;
      for (int i = 0; i < 8; i++) es[i] = lp_mode ? !(i < re) : (i != m_row);
      for (int r = 0; r < re; r++)
        for (int c = 0; c < ce; c++) if (keys[r][c]) ew = lp_mode;
      chk(lp_mode ? "R7" : "R2", "scan_out", 64'(scan_out), 64'(es));
      chk("R3", "key_map", key_map, m_key & kmask(re, ce));
      chk("R5", "press_flag", 64'(press_flag), 64'(m_pf));
      chk("R6", "release_flag", 64'(release_flag), 64'(m_rf));
      chk("R7", "wake", 64'(wake), 64'(ew));
      chk("R8", "reset_req", 64'(reset_req), 64'(m_rreq));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic clear_keys();
    for (int r = 0; r < 8; r++) keys[r] = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    clear_keys();
    cyc(3);
    rst = 1'b0;
    chk_on = 1;
    // R1 reset state
    chk("R1", "scan_out", 64'(scan_out), 64'h00FE);
    chk("R1", "key_map", key_map, 64'd0);
    chk("R1", "flags", 64'({press_flag, release_flag, reset_req}), 64'd0);

    // R4 / R5 single press
    keys[2][3] = 1'b1;
    cyc(80);
    chk("R4", "key_map single", key_map, 64'd1 << 19);
    chk("R5", "press set", 64'(press_flag), 64'd1);
    clr_press = 1'b1; cyc(1); clr_press = 1'b0; cyc(1);
    chk("R5", "press cleared", 64'(press_flag), 64'd0);

    // R3 glitch shorter than the debounce window
    cfg_dbnc = 4'd3;
    keys[5][5] = 1'b1; cyc(16); keys[5][5] = 1'b0;
    cyc(100);
    chk("R3", "glitch rejected", key_map, 64'd1 << 19);
    chk("R3", "no press on glitch", 64'(press_flag), 64'd0);

    // R6 release
    keys[2][3] = 1'b0;
    cyc(100);
    chk("R6", "release set", 64'(release_flag), 64'd1);
    chk("R6", "map empty", key_map, 64'd0);
    clr_release = 1'b1; cyc(1); clr_release = 1'b0; cyc(1);
    chk("R6", "release cleared", 64'(release_flag), 64'd0);

    // R3 zero debounce acts as one
    cfg_dbnc = 4'd0;
    keys[6][1] = 1'b1;
    cyc(40);
    chk("R3", "dbnc zero accept", key_map, 64'd1 << 49);
    keys[6][1] = 1'b0;
    cyc(40);
    clr_press = 1'b1; clr_release = 1'b1; cyc(1);
    clr_press = 1'b0; clr_release = 1'b0;

    // R4 keys outside the configured size
    cfg_rows = 4'd3; cfg_cols = 4'd3;
    keys[4][4] = 1'b1; keys[0][5] = 1'b1; keys[1][1] = 1'b1;
    cyc(100);
    chk("R4", "3x3 map", key_map, 64'd1 << 9);
    chk("R2", "rows 3..7 released", 64'(scan_out[7:3]), 64'h1F);
    // R2 clamping: 1 row -> 3, 15 cols -> 8
    cfg_rows = 4'd1; cfg_cols = 4'd15;
    cyc(100);
    chk("R2", "clamped size map", key_map, (64'd1 << 9) | (64'd1 << 5));
    cfg_rows = 4'd8; cfg_cols = 4'd8;
    clear_keys();
    cyc(100);
    clr_press = 1'b1; clr_release = 1'b1; cyc(1);
    clr_press = 1'b0; clr_release = 1'b0;

    // R8 three-key chord
    keys[0][0] = 1'b1; keys[1][2] = 1'b1; keys[7][7] = 1'b1;
    cyc(100);
    chk("R8", "chord asserts", 64'(reset_req), 64'd1);
    keys[1][2] = 1'b0;
    cyc(60);
    chk("R8", "chord drops", 64'(reset_req), 64'd0);
    cfg_rows = 4'd3; cfg_cols = 4'd3;
    keys[1][2] = 1'b1;
    cyc(100);
    chk("R8", "chord key out of range", 64'(reset_req), 64'd0);
    cfg_rows = 4'd8; cfg_cols = 4'd8;
    clear_keys();
    cyc(100);

    // R7 low-power wake
    lp_mode = 1'b1;
    cyc(2);
    chk("R7", "wake idle", 64'(wake), 64'd0);
    keys[3][6] = 1'b1;
    #1;
    chk("R7", "wake on key", 64'(wake), 64'd1);
    cyc(50);
    chk("R7", "map frozen", key_map, 64'd0);
    keys[3][6] = 1'b0;
    #1;
    chk("R7", "wake falls", 64'(wake), 64'd0);
    keys[3][6] = 1'b1;
    lp_mode = 1'b0;
    cyc(80);
    chk("R7", "scan resumes", key_map, 64'd1 << 30);

    done = 1;
    finish_run();
  end
endmodule